// File: doc/BRIEF.md
# Fractional-N Dual-Modulus Swallow Divider Control

This block steers the dual-modulus prescaler in the feedback path of a fractional-N synthesizer. It runs on the divided prescaler clock, where one clock cycle equals one prescaler output cycle. A feedback cycle spans B of these clock cycles. During the first A_eff cycles of each feedback cycle the block asks the prescaler for the larger modulus (PRESCALE+1). For the rest of the feedback cycle it asks for the base modulus (PRESCALE). This gives an integer divide of PRESCALE·B + A_eff. A single-cycle pulse marks the last clock cycle of each feedback cycle.

The fractional part comes from a first-order accumulator that advances once per reference-tick strobe. Each tick adds the numerator FN. When the sum reaches the modulus, the modulus is subtracted and the next feedback cycle swallows one extra count (A_eff = A+1). The modulus is not a power of two. A reference-select input chooses 1920 or 1968. Over a whole accumulator period the mean divide is PRESCALE·B + A + FN/modulus.

The B, A, FN and reference-select inputs are checked every clock. A legal setting is captured into a hold register. An illegal one raises an error flag and leaves the held setting untouched. The divider copies the held setting into its working registers only at the start of a feedback cycle.

Top module: `fracn_swallow_ctrl`

## Requirements
- R1: Each feedback cycle lasts exactly B clock cycles, and `fb_pulse` is high only on the last of them.
- R2: `mod_sel_hi` is high on the first A_eff clock cycles of a feedback cycle and low on the rest, with A_eff equal to A or A+1.
- R3: On every `ref_tick` the accumulator adds FN. When the sum reaches the modulus, the modulus is subtracted and the next feedback cycle starts with A_eff = A+1. With one tick per feedback cycle, any run of modulus consecutive feedback cycles holds exactly FN extended cycles.
- R4: The modulus is 1920 when `cfg_ref_sel` is 0 and 1968 when it is 1.
- R5: B values below 2 are illegal. B is 4 bits wide, so its legal range is 2 to 15.
- R6: A must not exceed PRESCALE−1 (0..7 for PRESCALE 8, 0..5 for PRESCALE 6), and A must be strictly less than B.
- R7: FN must be below the modulus selected by `cfg_ref_sel`: at most 1919 for select 0 and at most 1967 for select 1.
- R8: `cfg_err` goes high on the clock edge after an illegal setting is presented and clears on the edge after a legal one. While the setting is illegal, the divider keeps running on the last legal setting.
- R9: A new legal setting never changes the feedback cycle in progress. It takes effect from the next feedback cycle start.
- R10: Synchronous reset clears `mod_sel_hi`, `fb_pulse` and `cfg_err` and loads B=2, A=0, FN=0, select 0. As a result, `fb_pulse` rises on the first edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Divided prescaler clock, one cycle per prescaler output cycle |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick | input | 1 | Single-cycle strobe, once per reference period |
| cfg_b | input | 4 | Programmable count B |
| cfg_a | input | 3 | Swallow count A |
| cfg_fn | input | 11 | Fractional numerator FN |
| cfg_ref_sel | input | 1 | Modulus select: 0 gives 1920, 1 gives 1968 |
| mod_sel_hi | output | 1 | High requests prescaler modulus PRESCALE+1 |
| fb_pulse | output | 1 | High on the last clock cycle of each feedback cycle |
| cfg_err | output | 1 | High while the presented setting is illegal |

## Verification
The bench measures whole accumulator periods at each modulus. It uses FN values of zero, one, and the largest legal value for each modulus, and it drives one tick per feedback cycle. An accumulator that wrapped at the wrong modulus, or dropped or doubled a carry, would give a swallow total other than modulus·A + FN. It also runs the case A = B−1 with carries, where the extended cycle has the larger modulus for the whole feedback cycle; a design that overran A_eff there would break the per-cycle count. Each illegal setting class is presented: B too small, A equal to B, A over the prescaler limit on a 6-ratio instance, and FN at each modulus. A design that latched bad values would change the measured period. Finally, a setting changed at a cycle boundary must leave that cycle at its old length, so a design that applied settings early would lengthen or shorten it.

// File: rtl/fnsc_pkg.sv
package fnsc_pkg;
  localparam int B_W  = 4;
  localparam int A_W  = 3;
  localparam int FN_W = 11;

  typedef struct packed {
    logic [B_W-1:0]  b;
    logic [A_W-1:0]  a;
    logic [FN_W-1:0] fn;
    logic            sel;
  } fnsc_cfg_t;

  localparam fnsc_cfg_t CFG_RST = '{b: 4'd2, a: 3'd0, fn: 11'd0, sel: 1'b0};
endpackage

// File: rtl/fnsc_cfg_check.sv
module fnsc_cfg_check
  import fnsc_pkg::*;
#(
  parameter int PRESCALE = 8,
  parameter int MOD_LO   = 1920,
  parameter int MOD_HI   = 1968
) (
  input  fnsc_cfg_t cfg,
  output logic      legal
);
  localparam int B_MIN = 2;
  localparam int A_MAX = PRESCALE - 1;

  logic b_ok, a_ok, fn_ok;
  int   fn_lim;

  always_comb begin
    fn_lim = cfg.sel ? MOD_HI : MOD_LO;
    b_ok   = int'(cfg.b) >= B_MIN;
    a_ok   = (int'(cfg.a) <= A_MAX) && (int'(cfg.a) < int'(cfg.b));
    fn_ok  = int'(cfg.fn) < fn_lim;
    legal  = b_ok && a_ok && fn_ok;
  end
endmodule

// File: rtl/fnsc_cfg_hold.sv
module fnsc_cfg_hold
  import fnsc_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  fnsc_cfg_t cfg_in,
  input  logic      legal,
  output fnsc_cfg_t hold_q,
  output logic      err_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= CFG_RST;
      err_q  <= 1'b0;
    end else begin
      err_q <= !legal;
      if (legal) hold_q <= cfg_in;
    end
  end
endmodule

// File: rtl/fnsc_frac_acc.sv
module fnsc_frac_acc #(
  parameter int FN_W   = 11,
  parameter int MOD_LO = 1920,
  parameter int MOD_HI = 1968,
  localparam int ACC_W = FN_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic [FN_W-1:0]  fn,
  input  logic             sel,
  input  logic             consume,
  output logic             carry_q,
  output logic [ACC_W-1:0] acc_q
);
  logic [ACC_W-1:0] sum, modv;
  logic             ovf;

  always_comb begin
    sum  = acc_q + ACC_W'(fn);
    modv = sel ? ACC_W'(MOD_HI) : ACC_W'(MOD_LO);
    ovf  = sum >= modv;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q   <= '0;
      carry_q <= 1'b0;
    end else begin
      if (tick) acc_q <= ovf ? (sum - modv) : sum;
      if (tick && ovf)  carry_q <= 1'b1;
      else if (consume) carry_q <= 1'b0;
    end
  end
endmodule

// File: rtl/fnsc_swallow_seq.sv
module fnsc_swallow_seq #(
  parameter int B_W   = 4,
  parameter int A_W   = 3,
  parameter int B_RST = 2,
  localparam int AE_W = A_W + 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [B_W-1:0]  hold_b,
  input  logic [A_W-1:0]  hold_a,
  input  logic            carry,
  output logic            boundary,
  output logic            mod_hi_q,
  output logic            pulse_q,
  output logic [B_W-1:0]  act_b_q,
  output logic [AE_W-1:0] act_a_q
);
  logic [B_W-1:0]  cnt_q, cnt_n, b_n;
  logic [AE_W-1:0] a_n;
  logic            mod_n, pulse_n;

  always_comb begin
    boundary = cnt_q == (act_b_q - B_W'(1));
    if (boundary) begin
      cnt_n = '0;
      b_n   = hold_b;
      a_n   = AE_W'(hold_a) + AE_W'(carry);
    end else begin
      cnt_n = cnt_q + B_W'(1);
      b_n   = act_b_q;
      a_n   = act_a_q;
    end
    mod_n   = int'(cnt_n) < int'(a_n);
    pulse_n = cnt_n == (b_n - B_W'(1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      act_b_q  <= B_W'(B_RST);
      act_a_q  <= '0;
      mod_hi_q <= 1'b0;
      pulse_q  <= 1'b0;
    end else begin
      cnt_q    <= cnt_n;
      act_b_q  <= b_n;
      act_a_q  <= a_n;
      mod_hi_q <= mod_n;
      pulse_q  <= pulse_n;
    end
  end
endmodule

// File: rtl/fracn_swallow_ctrl.sv
module fracn_swallow_ctrl
  import fnsc_pkg::*;
#(
  parameter int PRESCALE = 8,
  parameter int MOD_LO   = 1920,
  parameter int MOD_HI   = 1968
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ref_tick,
  input  logic [B_W-1:0]  cfg_b,
  input  logic [A_W-1:0]  cfg_a,
  input  logic [FN_W-1:0] cfg_fn,
  input  logic            cfg_ref_sel,
  output logic            mod_sel_hi,
  output logic            fb_pulse,
  output logic            cfg_err
);
  localparam int ACC_W = FN_W + 1;
  localparam int AE_W  = A_W + 1;

  fnsc_cfg_t        cfg_in, hold_q;
  logic             legal, consume, carry;
  logic [ACC_W-1:0] acc_q;
  logic [B_W-1:0]   act_b;
  logic [AE_W-1:0]  act_a;

  assign cfg_in = '{b: cfg_b, a: cfg_a, fn: cfg_fn, sel: cfg_ref_sel};

  fnsc_cfg_check #(.PRESCALE(PRESCALE), .MOD_LO(MOD_LO), .MOD_HI(MOD_HI)) u_check (
    .cfg(cfg_in), .legal(legal)
  );

  fnsc_cfg_hold u_hold (
    .clk(clk), .rst(rst), .cfg_in(cfg_in), .legal(legal),
    .hold_q(hold_q), .err_q(cfg_err)
  );

  fnsc_frac_acc #(.FN_W(FN_W), .MOD_LO(MOD_LO), .MOD_HI(MOD_HI)) u_acc (
    .clk(clk), .rst(rst), .tick(ref_tick), .fn(hold_q.fn), .sel(hold_q.sel),
    .consume(consume), .carry_q(carry), .acc_q(acc_q)
  );

  fnsc_swallow_seq #(.B_W(B_W), .A_W(A_W), .B_RST(int'(CFG_RST.b))) u_seq (
    .clk(clk), .rst(rst), .hold_b(hold_q.b), .hold_a(hold_q.a), .carry(carry),
    .boundary(consume), .mod_hi_q(mod_sel_hi), .pulse_q(fb_pulse),
    .act_b_q(act_b), .act_a_q(act_a)
  );
endmodule

// File: rtl/fnsc_chk.sv
module fnsc_chk
  import fnsc_pkg::*;
#(
  parameter int MOD_HI = 1968
) (
  input logic            clk,
  input logic            rst,
  input logic            fb_pulse,
  input logic            mod_sel_hi,
  input logic            cfg_err,
  input fnsc_cfg_t       hold_q,
  input logic [FN_W:0]   acc_q,
  input logic [B_W-1:0]  act_b,
  input logic [A_W:0]    act_a
);
  // R1
  period_min_chk: assert property (@(posedge clk) disable iff (rst)
    fb_pulse |=> !fb_pulse);

  // R2
  swallow_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(mod_sel_hi) |-> $past(fb_pulse));

  // R6
  swallow_bound_chk: assert property (@(posedge clk) disable iff (rst)
    int'(act_a) <= int'(act_b));

  // R5
  b_floor_chk: assert property (@(posedge clk) disable iff (rst)
    int'(act_b) >= 2);

  // R4
  acc_range_chk: assert property (@(posedge clk) disable iff (rst)
    int'(acc_q) < MOD_HI);

  // R8
  hold_keep_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_err |-> $stable(hold_q));
endmodule

bind fracn_swallow_ctrl fnsc_chk #(.MOD_HI(MOD_HI)) u_chk (
  .clk(clk), .rst(rst), .fb_pulse(fb_pulse), .mod_sel_hi(mod_sel_hi),
  .cfg_err(cfg_err), .hold_q(hold_q), .acc_q(acc_q), .act_b(act_b), .act_a(act_a)
);

// File: tb/fracn_swallow_ctrl_tb.sv
module fracn_swallow_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  typedef struct packed {
    logic [3:0]  b;
    logic [2:0]  a;
    logic [10:0] fn;
    logic        sel;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{b: 4'd3,  a: 3'd1, fn: 11'd0,    sel: 1'b0},
    '{b: 4'd4,  a: 3'd2, fn: 11'd1,    sel: 1'b0},
    '{b: 4'd5,  a: 3'd0, fn: 11'd1919, sel: 1'b0},
    '{b: 4'd6,  a: 3'd5, fn: 11'd1967, sel: 1'b1},
    '{b: 4'd2,  a: 3'd1, fn: 11'd960,  sel: 1'b0},
    '{b: 4'd15, a: 3'd7, fn: 11'd1000, sel: 1'b1}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ref_tick = 1'b0;
  logic [3:0]  cfg_b = 4'd7;
  logic [2:0]  cfg_a = 3'd3;
  logic [10:0] cfg_fn = '0;
  logic        cfg_ref_sel = 1'b0;
  logic        mod_sel_hi, fb_pulse, cfg_err;

  logic [3:0]  b6 = 4'd9;
  logic [2:0]  a6 = 3'd0;
  logic        mod6, pulse6, err6;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fracn_swallow_ctrl dut_i (
    .clk(clk), .rst(rst), .ref_tick(ref_tick), .cfg_b(cfg_b), .cfg_a(cfg_a),
    .cfg_fn(cfg_fn), .cfg_ref_sel(cfg_ref_sel), .mod_sel_hi(mod_sel_hi),
    .fb_pulse(fb_pulse), .cfg_err(cfg_err)
  );

  fracn_swallow_ctrl #(.PRESCALE(6)) dut6_i (
    .clk(clk), .rst(rst), .ref_tick(ref_tick), .cfg_b(b6), .cfg_a(a6),
    .cfg_fn(11'd0), .cfg_ref_sel(1'b0), .mod_sel_hi(mod6),
    .fb_pulse(pulse6), .cfg_err(err6)
  );

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic set_cfg(input int b, input int a, input int fn, input bit sel);
    cfg_b = 4'(b); cfg_a = 3'(a); cfg_fn = 11'(fn); cfg_ref_sel = sel;
  endtask

  task automatic wait_pulse();
    do @(negedge clk); while (!fb_pulse);
  endtask

  task automatic measure(output int n, output int hi);
    n = 0; hi = 0;
    do begin
      @(negedge clk);
      n++;
      if (mod_sel_hi) hi++;
    end while (!fb_pulse);
  endtask

  // one reference tick per feedback cycle
  initial begin
    forever begin
      @(negedge clk);
      ref_tick = fb_pulse;
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", WATCHDOG, 0);
    finish_run();
  end

  initial begin
    int n, hi;
    // R10: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!mod_sel_hi && !fb_pulse && !cfg_err, "R10 outputs in reset",
        {mod_sel_hi, fb_pulse, cfg_err}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(fb_pulse == 1'b1, "R10 default B=2 pulse after release", fb_pulse, 1);
    measure(n, hi);
    chk(n == 7, "R1 period B=7", n, 7);
    chk(hi == 3, "R2 swallow count A=3", hi, 3);

    // R9: change applied at a boundary keeps current cycle length
    set_cfg(4, 1, 0, 0);
    repeat (3) wait_pulse();
    set_cfg(6, 2, 0, 0);
    measure(n, hi);
    chk(n == 4 && hi == 1, "R9 cycle after change keeps old setting", n, 4);
    measure(n, hi);
    chk(n == 6 && hi == 2, "R9 following cycle uses new setting", n, 6);

    // R8 with R5, R6, R7, R4: illegal settings flag and are ignored
    set_cfg(4, 1, 0, 0);
    repeat (3) wait_pulse();
    for (int k = 0; k < 5; k++) begin
      case (k)
        0: set_cfg(1, 0, 0, 0);      // R5 B below 2
        1: set_cfg(0, 0, 0, 0);      // R5 B zero
        2: set_cfg(3, 3, 0, 0);      // R6 A equal to B
        3: set_cfg(4, 1, 1920, 0);   // R7 FN at modulus 1920
        default: set_cfg(4, 1, 1968, 1); // R7 R4 FN at modulus 1968
      endcase
      @(negedge clk);
      chk(cfg_err == 1'b1, "R8 error flag on illegal setting", cfg_err, 1);
      wait_pulse();
      measure(n, hi);
      chk(n == 4 && hi == 1, "R8 divider holds B=4 A=1", n * 10 + hi, 41);
    end
    set_cfg(4, 1, 1920, 1);
    @(negedge clk);
    chk(cfg_err == 1'b0, "R4 FN=1920 legal with select 1", cfg_err, 0);

    // R6: prescaler-6 instance limits A to 5
    b6 = 4'd9; a6 = 3'd6;
    @(negedge clk);
    chk(err6 == 1'b1, "R6 A=6 illegal for prescaler 6", err6, 1);
    a6 = 3'd5;
    @(negedge clk);
    chk(err6 == 1'b0, "R6 A=5 legal for prescaler 6", err6, 0);

    // R1 R2 R3 R4: whole accumulator periods from the vector table
    for (int v = 0; v < NV; v++) begin
      int m, tot, toth, bad;
      set_cfg(int'(VECS[v].b), int'(VECS[v].a), int'(VECS[v].fn), VECS[v].sel);
      repeat (4) wait_pulse();
      m = VECS[v].sel ? 1968 : 1920;
      tot = 0; toth = 0; bad = 0;
      for (int c = 0; c < m; c++) begin
        measure(n, hi);
        tot += n;
        toth += hi;
        if (hi < int'(VECS[v].a) || hi > int'(VECS[v].a) + 1) bad++;
      end
      chk(tot == m * int'(VECS[v].b), "R1 total cycles over period", tot, m * int'(VECS[v].b));
      chk(toth == m * int'(VECS[v].a) + int'(VECS[v].fn), "R3 R4 swallow total",
          toth, m * int'(VECS[v].a) + int'(VECS[v].fn));
      chk(bad == 0, "R2 per-cycle swallow in {A,A+1}", bad, 0);
    end

    // R10: reset mid-run clears outputs
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk(!mod_sel_hi && !fb_pulse && !cfg_err, "R10 outputs after mid-run reset",
        {mod_sel_hi, fb_pulse, cfg_err}, 0);
    finish_run();
  end
endmodule